// File: doc/BRIEF.md
# Paged DMA Address Translator

This block turns I/O addresses issued by DMA-capable devices into physical addresses. It looks each address up in a table of translation entries held in on-chip storage. Software first fills the table through a simple write port. It then opens a translation window with three settings: a bus offset where the window starts, a page shift that sets the page size, and an entry count that sets how many pages the window spans. Each table entry holds a physical page base, and its two lowest bits hold a permission code.

For every request the block answers one cycle later. The answer carries the translated physical address, the window-relative I/O page base, the offset mask of the page, the permission code of the entry, and a fault flag. The fault flag is raised when the address falls outside the window or when the entry does not allow the requested direction. Disabling the window clears the configuration and every entry. Reset leaves the table disabled and all entries zero.

Top module: `dxl_xlate`

## Requirements
- R1: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high, and every request gets one response.
- R2: The table index is (`req_addr` − bus offset) shifted right by the page shift, with the subtraction wrapping, so addresses below the offset land far out of range. An index at or beyond the entry count, or any request while the table is disabled, returns `rsp_perm`=0, `rsp_fault`=1, `rsp_mask` all ones, and `rsp_pa`=`rsp_iova`=0.
- R3: Entry bits [1:0] hold the permission code and are reported on `rsp_perm`: 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R4: A read (`req_write`=0) is granted only for codes 1 and 3. A write (`req_write`=1) is granted only for codes 2 and 3. A request that is not granted raises `rsp_fault`.
- R5: For an in-window request, `rsp_pa` is the entry with its bits below the page shift cleared, ORed with the `req_addr` bits below the page shift. `rsp_iova` is the window-relative address with its bits below the page shift cleared.
- R6: For an in-window request, `rsp_mask` equals 2^shift − 1.
- R7: A `cfg_enable` pulse while the table is disabled loads the offset, the page shift and the entry count. A shift below 12 is raised to 12 and a shift above 24 is lowered to 24. A count above the table depth (default 64) is lowered to the depth. A loaded count of 0 leaves the table disabled.
- R8: A `cfg_enable` pulse while the table is enabled (count not zero) has no effect.
- R9: A `cfg_disable` pulse sets the offset, shift and count to zero and zeroes every entry. It wins over a `cfg_enable` in the same cycle.
- R10: After reset the table is disabled and every entry reads as zero.
- R11: `tbl_we` writes `tbl_data` into the entry at `tbl_idx`, and the new value is used by requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_enable | input | 1 | Enable pulse; loads window settings when disabled |
| cfg_disable | input | 1 | Disable pulse; clears settings and entries |
| cfg_shift | input | SHIFT_W (5) | Requested page shift |
| cfg_offset | input | ADDR_W (40) | Bus offset of the window |
| cfg_count | input | CNT_IN_W (16) | Requested entry count |
| tbl_we | input | 1 | Entry write strobe |
| tbl_idx | input | IDX_W (6) | Entry index to write |
| tbl_data | input | ENT_W (40) | Entry value: page base, permission in bits [1:0] |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W (40) | I/O address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_pa | output | ENT_W (40) | Translated physical address |
| rsp_iova | output | ADDR_W (40) | Window-relative I/O page base |
| rsp_mask | output | ADDR_W (40) | Page offset mask, all ones when out of range |
| rsp_perm | output | 2 | Permission code of the entry |
| rsp_fault | output | 1 | Access not allowed |

## Verification
The assertions assume that a table write or a configuration pulse never falls in the same cycle as a request that depends on it. They also assume that `req_addr` and `req_write` are meaningful whenever `req_valid` is high. The stimulus places every table write and every enable or disable pulse in cycles of their own, ahead of the requests that test them. The only exception is the back-to-back request bursts, which contain nothing but requests. Clamped shift values reach the checker only after the configuration logic has clamped them, so the range property watches the stored shift rather than the raw input.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RD   = 2'd1,
    PERM_WR   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  // Grant test: bit 0 of the code allows reads, bit 1 allows writes.
  function automatic logic access_ok(input perm_e p, input logic is_wr);
    logic [1:0] code;
    code = p;
    return is_wr ? code[1] : code[0];
  endfunction

endpackage

// File: rtl/dxl_cfg.sv
module dxl_cfg #(
  parameter int ADDR_W   = 40,
  parameter int SHIFT_W  = 5,
  parameter int CNT_IN_W = 16,
  parameter int CNT_W    = 7,
  parameter int DEPTH    = 64,
  parameter int SHIFT_LO = 12,
  parameter int SHIFT_HI = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                dis_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  input  logic [ADDR_W-1:0]   offset_i,
  input  logic [CNT_IN_W-1:0] count_i,
  output logic [SHIFT_W-1:0]  shift_o,
  output logic [ADDR_W-1:0]   offset_o,
  output logic [CNT_W-1:0]    count_o
);

  localparam logic [SHIFT_W-1:0]  LO_V    = SHIFT_W'(SHIFT_LO);
  localparam logic [SHIFT_W-1:0]  HI_V    = SHIFT_W'(SHIFT_HI);
  localparam logic [CNT_IN_W-1:0] DEPTH_V = CNT_IN_W'(DEPTH);

  logic [SHIFT_W-1:0] shift_q, shift_d, shift_clamped;
  logic [ADDR_W-1:0]  offset_q, offset_d;
  logic [CNT_W-1:0]   count_q, count_d, count_clamped;
  logic               active;
  logic               load;

  always_comb begin
    if (shift_i < LO_V)      shift_clamped = LO_V;
    else if (shift_i > HI_V) shift_clamped = HI_V;
    else                     shift_clamped = shift_i;

    if (count_i > DEPTH_V)   count_clamped = CNT_W'(DEPTH);
    else                     count_clamped = count_i[CNT_W-1:0];
  end

  assign active = (count_q != '0);
  assign load   = en_i && !active;

  always_comb begin
    shift_d  = shift_q;
    offset_d = offset_q;
    count_d  = count_q;
    if (dis_i) begin
      shift_d  = '0;
      offset_d = '0;
      count_d  = '0;
    end else if (load) begin
      shift_d  = shift_clamped;
      offset_d = offset_i;
      count_d  = count_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      offset_q <= '0;
      count_q  <= '0;
    end else if (dis_i || load) begin
      shift_q  <= shift_d;
      offset_q <= offset_d;
      count_q  <= count_d;
    end
  end

  assign shift_o  = shift_q;
  assign offset_o = offset_q;
  assign count_o  = count_q;

endmodule

// File: rtl/dxl_table.sv
module dxl_table #(
  parameter int DEPTH = 64,
  parameter int ENT_W = 40,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [ENT_W-1:0] rdata_o
);

  logic [ENT_W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [ENT_W-1:0] q, d;
    logic             sel;

    assign sel = we_i && (widx_i == IDX_W'(g));

    always_comb begin
      if (clr_i)    d = '0;
      else if (sel) d = wdata_i;
      else          d = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             q <= '0;
      else if (clr_i || sel)  q <= d;
    end

    assign ent[g] = q;
  end

  always_comb begin
    if (32'(ridx_i) < DEPTH) rdata_o = ent[ridx_i];
    else                     rdata_o = '0;
  end

endmodule

// File: rtl/dxl_lookup.sv
module dxl_lookup
  import dxl_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int ENT_W   = 40,
  parameter int SHIFT_W = 5,
  parameter int CNT_W   = 7,
  parameter int IDX_W   = 6
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               is_wr_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [ADDR_W-1:0]  offset_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [ENT_W-1:0]   entry_i,
  output logic [IDX_W-1:0]   ridx_o,
  output logic [ENT_W-1:0]   pa_o,
  output logic [ADDR_W-1:0]  iova_o,
  output logic [ADDR_W-1:0]  mask_o,
  output perm_e              perm_o,
  output logic               fault_o
);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] idx_full;
  logic [ADDR_W-1:0] low_a;
  logic [ENT_W-1:0]  low_e;
  logic [ENT_W-1:0]  addr_e;
  logic              in_win;
  perm_e             code;

  assign rel      = addr_i - offset_i;
  assign idx_full = rel >> shift_i;
  assign in_win   = idx_full < {{(ADDR_W-CNT_W){1'b0}}, count_i};
  assign ridx_o   = idx_full[IDX_W-1:0];

  assign low_a  = ({{(ADDR_W-1){1'b0}}, 1'b1} << shift_i) - 1'b1;
  assign low_e  = ({{(ENT_W-1){1'b0}}, 1'b1} << shift_i) - 1'b1;
  assign addr_e = ENT_W'(addr_i);
  assign code   = perm_e'(entry_i[1:0]);

  always_comb begin
    if (in_win) begin
      pa_o    = (entry_i & ~low_e) | (addr_e & low_e);
      iova_o  = rel & ~low_a;
      mask_o  = low_a;
      perm_o  = code;
      fault_o = !access_ok(code, is_wr_i);
    end else begin
      pa_o    = '0;
      iova_o  = '0;
      mask_o  = '1;
      perm_o  = PERM_NONE;
      fault_o = 1'b1;
    end
  end

endmodule

// File: rtl/dxl_xlate.sv
module dxl_xlate
  import dxl_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int ENT_W    = 40,
  parameter int DEPTH    = 64,
  parameter int SHIFT_W  = 5,
  parameter int CNT_IN_W = 16,
  parameter int SHIFT_LO = 12,
  parameter int SHIFT_HI = 24,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_enable,
  input  logic                cfg_disable,
  input  logic [SHIFT_W-1:0]  cfg_shift,
  input  logic [ADDR_W-1:0]   cfg_offset,
  input  logic [CNT_IN_W-1:0] cfg_count,
  input  logic                tbl_we,
  input  logic [IDX_W-1:0]    tbl_idx,
  input  logic [ENT_W-1:0]    tbl_data,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                rsp_valid,
  output logic [ENT_W-1:0]    rsp_pa,
  output logic [ADDR_W-1:0]   rsp_iova,
  output logic [ADDR_W-1:0]   rsp_mask,
  output logic [1:0]          rsp_perm,
  output logic                rsp_fault
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [SHIFT_W-1:0] cfg_shift_q;
  logic [ADDR_W-1:0]  cfg_offset_q;
  logic [CNT_W-1:0]   cfg_count_q;

  dxl_cfg #(
    .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W), .CNT_IN_W(CNT_IN_W), .CNT_W(CNT_W),
    .DEPTH(DEPTH), .SHIFT_LO(SHIFT_LO), .SHIFT_HI(SHIFT_HI)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en_i     (cfg_enable),
    .dis_i    (cfg_disable),
    .shift_i  (cfg_shift),
    .offset_i (cfg_offset),
    .count_i  (cfg_count),
    .shift_o  (cfg_shift_q),
    .offset_o (cfg_offset_q),
    .count_o  (cfg_count_q)
  );

  logic [IDX_W-1:0] rd_idx;
  logic [ENT_W-1:0] rd_entry;

  dxl_table #(.DEPTH(DEPTH), .ENT_W(ENT_W), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr_i   (cfg_disable),
    .we_i    (tbl_we),
    .widx_i  (tbl_idx),
    .wdata_i (tbl_data),
    .ridx_i  (rd_idx),
    .rdata_o (rd_entry)
  );

  logic [ENT_W-1:0]  lk_pa;
  logic [ADDR_W-1:0] lk_iova;
  logic [ADDR_W-1:0] lk_mask;
  perm_e             lk_perm;
  logic              lk_fault;

  dxl_lookup #(
    .ADDR_W(ADDR_W), .ENT_W(ENT_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_lookup (
    .addr_i   (req_addr),
    .is_wr_i  (req_write),
    .shift_i  (cfg_shift_q),
    .offset_i (cfg_offset_q),
    .count_i  (cfg_count_q),
    .entry_i  (rd_entry),
    .ridx_o   (rd_idx),
    .pa_o     (lk_pa),
    .iova_o   (lk_iova),
    .mask_o   (lk_mask),
    .perm_o   (lk_perm),
    .fault_o  (lk_fault)
  );

  // Response register: next-state logic, then the flops.
  logic              v_q, v_d;
  logic [ENT_W-1:0]  pa_q, pa_d;
  logic [ADDR_W-1:0] iova_q, iova_d;
  logic [ADDR_W-1:0] mask_q, mask_d;
  logic [1:0]        perm_q, perm_d;
  logic              fault_q, fault_d;

  always_comb begin
    v_d     = req_valid;
    pa_d    = lk_pa;
    iova_d  = lk_iova;
    mask_d  = lk_mask;
    perm_d  = lk_perm;
    fault_d = lk_fault;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) v_q <= 1'b0;
    else             v_q <= v_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pa_q    <= '0;
      iova_q  <= '0;
      mask_q  <= '0;
      perm_q  <= '0;
      fault_q <= 1'b0;
    end else if (req_valid) begin
      pa_q    <= pa_d;
      iova_q  <= iova_d;
      mask_q  <= mask_d;
      perm_q  <= perm_d;
      fault_q <= fault_d;
    end
  end

  assign rsp_valid = v_q;
  assign rsp_pa    = pa_q;
  assign rsp_iova  = iova_q;
  assign rsp_mask  = mask_q;
  assign rsp_perm  = perm_q;
  assign rsp_fault = fault_q;

endmodule

// File: rtl/dxl_xlate_chk.sv
module dxl_xlate_chk #(
  parameter int ADDR_W   = 40,
  parameter int ENT_W    = 40,
  parameter int SHIFT_W  = 5,
  parameter int CNT_W    = 7,
  parameter int SHIFT_LO = 12,
  parameter int SHIFT_HI = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               cfg_enable,
  input logic               cfg_disable,
  input logic               rsp_valid,
  input logic [ENT_W-1:0]   rsp_pa,
  input logic [ADDR_W-1:0]  rsp_mask,
  input logic [1:0]         rsp_perm,
  input logic               rsp_fault,
  input logic [SHIFT_W-1:0] cfg_shift_q,
  input logic [ADDR_W-1:0]  cfg_offset_q,
  input logic [CNT_W-1:0]   cfg_count_q
);

  localparam logic [ADDR_W-1:0] ONES = '1;

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_oob_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mask == ONES) |-> (rsp_fault && rsp_perm == 2'd0 && rsp_pa == '0));

  assert_none_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perm == 2'd0) |-> rsp_fault);

  assert_grant_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> ($past(req_write) ? rsp_perm[1] : rsp_perm[0]));

  assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mask != ONES) |->
      (((rsp_pa ^ ENT_W'($past(req_addr))) & ENT_W'(rsp_mask)) == '0));

  assert_mask_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mask != ONES) |->
      (rsp_mask[SHIFT_LO-1:0] == '1 && rsp_mask[SHIFT_HI] == 1'b0 &&
       ((rsp_mask + 1'b1) & rsp_mask) == '0));

  assert_shift_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_count_q != '0) |->
      (cfg_shift_q >= SHIFT_W'(SHIFT_LO) && cfg_shift_q <= SHIFT_W'(SHIFT_HI)));

  assert_enable_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && !cfg_disable && cfg_count_q != '0) |=>
      ($stable(cfg_count_q) && $stable(cfg_shift_q) && $stable(cfg_offset_q)));

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_disable |=> (cfg_count_q == '0 && cfg_shift_q == '0 && cfg_offset_q == '0));

endmodule

bind dxl_xlate dxl_xlate_chk #(
  .ADDR_W(ADDR_W), .ENT_W(ENT_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W),
  .SHIFT_LO(SHIFT_LO), .SHIFT_HI(SHIFT_HI)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .cfg_enable   (cfg_enable),
  .cfg_disable  (cfg_disable),
  .rsp_valid    (rsp_valid),
  .rsp_pa       (rsp_pa),
  .rsp_mask     (rsp_mask),
  .rsp_perm     (rsp_perm),
  .rsp_fault    (rsp_fault),
  .cfg_shift_q  (cfg_shift_q),
  .cfg_offset_q (cfg_offset_q),
  .cfg_count_q  (cfg_count_q)
);

// File: tb/dxl_xlate_tb.sv
module dxl_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_disable = 1'b0;
  logic [4:0]  cfg_shift = '0;
  logic [39:0] cfg_offset = '0;
  logic [15:0] cfg_count = '0;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_idx = '0;
  logic [39:0] tbl_data = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [39:0] req_addr = '0;
  logic        rsp_valid;
  logic [39:0] rsp_pa, rsp_iova, rsp_mask;
  logic [1:0]  rsp_perm;
  logic        rsp_fault;

  always #2 clk = ~clk;  // 250 MHz

  dxl_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_enable(cfg_enable), .cfg_disable(cfg_disable),
    .cfg_shift(cfg_shift), .cfg_offset(cfg_offset), .cfg_count(cfg_count),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_iova(rsp_iova),
    .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

  typedef struct packed {
    logic [39:0] pa;
    logic [39:0] iova;
    logic [39:0] mask;
    logic [1:0]  perm;
    logic        fault;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;

  // Reference state built from the requirements.
  logic [39:0] m_tab [64];
  logic [4:0]  m_shift;
  logic [39:0] m_off;
  int          m_cnt;

  task automatic model_clear();
    for (int i = 0; i < 64; i++) m_tab[i] = '0;
    m_shift = '0; m_off = '0; m_cnt = 0;
  endtask

  function automatic exp_t predict(input logic [39:0] addr, input logic wr);
    exp_t        e;
    logic [39:0] rel, idx, low, ent;
    rel = addr - m_off;
    idx = rel >> m_shift;
    if (m_cnt == 0 || idx >= 40'(m_cnt)) begin
      e.pa = '0; e.iova = '0; e.mask = '1; e.perm = 2'd0; e.fault = 1'b1;
    end else begin
      ent    = m_tab[idx[5:0]];
      low    = (40'd1 << m_shift) - 40'd1;
      e.pa   = (ent & ~low) | (addr & low);
      e.iova = rel & ~low;
      e.mask = low;
      e.perm = ent[1:0];
      e.fault = wr ? !ent[1] : !ent[0];
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", what);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    check(rsp_valid == 1'b0, $sformatf("R10 rsp_valid in reset act=%0b exp=0", rsp_valid));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_enable(input logic [4:0] sh, input logic [39:0] off, input int cnt);
    cfg_shift = sh; cfg_offset = off; cfg_count = 16'(cnt); cfg_enable = 1'b1;
    @(negedge clk);
    cfg_enable = 1'b0;
    if (m_cnt == 0) begin
      m_shift = (sh < 5'd12) ? 5'd12 : ((sh > 5'd24) ? 5'd24 : sh);
      m_off   = off;
      m_cnt   = (cnt > 64) ? 64 : cnt;
      if (m_cnt == 0) begin m_shift = '0; m_off = '0; end
    end
  endtask

  task automatic do_disable();
    cfg_disable = 1'b1;
    @(negedge clk);
    cfg_disable = 1'b0;
    model_clear();
  endtask

  task automatic do_write(input int idx, input logic [39:0] data);
    tbl_we = 1'b1; tbl_idx = 6'(idx); tbl_data = data;
    @(negedge clk);
    tbl_we = 1'b0;
    m_tab[idx] = data;
  endtask

  task automatic do_req(input logic [39:0] addr, input logic wr, input string tag);
    req_valid = 1'b1; req_addr = addr; req_write = wr;
    exp_q.push_back(predict(addr, wr));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compares each response against the front of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 response without request act=1 exp=0");
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_pa == e.pa && rsp_iova == e.iova && rsp_mask == e.mask &&
              rsp_perm == e.perm && rsp_fault == e.fault,
              $sformatf("%s act pa=%h iova=%h mask=%h perm=%0d fault=%0b exp pa=%h iova=%h mask=%h perm=%0d fault=%0b",
                        t, rsp_pa, rsp_iova, rsp_mask, rsp_perm, rsp_fault,
                        e.pa, e.iova, e.mask, e.perm, e.fault));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [39:0] OFF_A = 40'h00_1000_0000;

  initial begin
    model_clear();
    do_reset();

    // R10 / R2: disabled after reset, every request faults.
    do_req(40'h00_0000_1234, 1'b0, "R10 R2 disabled table read");
    do_req(OFF_A, 1'b1, "R10 R2 disabled table write");
    settle();

    // Fill entries, open a 4 KiB-page window of 8 entries.
    do_write(0, 40'h00_ABCD_E000);   // code 0
    do_write(1, 40'h12_3456_7001);   // code 1, read only
    do_write(2, 40'h00_0040_0FF2);   // code 2, write only, junk low bits
    do_write(3, 40'h3F_FFFF_F003);   // code 3
    do_write(7, 40'h00_0000_8003);
    do_enable(5'd12, OFF_A, 8);

    do_req(OFF_A + 40'h0000_0ABC, 1'b0, "R3 R4 code0 read");
    do_req(OFF_A + 40'h0000_1010, 1'b0, "R4 R5 code1 read granted");
    do_req(OFF_A + 40'h0000_1010, 1'b1, "R4 code1 write denied");
    do_req(OFF_A + 40'h0000_2FFF, 1'b1, "R4 R5 code2 write granted");
    do_req(OFF_A + 40'h0000_2000, 1'b0, "R4 code2 read denied");
    do_req(OFF_A + 40'h0000_3777, 1'b1, "R3 R5 R6 code3 write");
    do_req(OFF_A + 40'h0000_3001, 1'b0, "R3 R1 code3 read back to back");
    do_req(OFF_A + 40'h0000_7FFF, 1'b0, "R2 last index in range");
    do_req(OFF_A + 40'h0000_8000, 1'b0, "R2 index equals count");
    do_req(OFF_A - 40'h1, 1'b0, "R2 address below offset");
    settle();

    // R11: a written entry is used by the very next request.
    do_write(4, 40'h00_7777_7002);
    do_req(OFF_A + 40'h0000_4123, 1'b1, "R11 write then immediate request");
    settle();

    // R8: second enable is ignored.
    do_enable(5'd16, 40'h0, 2);
    do_req(OFF_A + 40'h0000_1555, 1'b0, "R8 enable while enabled ignored");
    do_req(40'h00_0000_1555, 1'b0, "R8 new window not applied");
    settle();

    // R9: disable clears settings and entries.
    do_disable();
    do_req(OFF_A + 40'h0000_1555, 1'b0, "R9 disabled request faults");
    settle();
    do_enable(5'd16, 40'h0, 4);
    do_req(40'h00_0001_2345, 1'b0, "R9 entries zeroed after disable");
    do_write(2, 40'h55_5555_1233);
    do_req(40'h00_0002_ABCD, 1'b1, "R6 R5 64 KiB page write");
    do_req(40'h00_0004_0000, 1'b0, "R2 64 KiB page past count");
    settle();

    // R7: clamping of shift and count.
    do_disable();
    do_enable(5'd5, 40'h00_2000_0000, 1000);
    do_write(63, 40'h01_0000_0001);
    do_req(40'h00_2003_F0A5, 1'b0, "R7 shift raised to 12 count lowered to 64 last entry");
    do_req(40'h00_2004_0000, 1'b0, "R7 index 64 faults after clamp");
    settle();
    do_disable();
    do_enable(5'd30, 40'h0, 2);
    do_write(1, 40'hFF_FF00_0003);
    do_req(40'h00_01AB_CDEF, 1'b0, "R7 shift lowered to 24");
    do_req(40'h00_0200_0000, 1'b1, "R7 R2 index 2 of 2 faults");
    settle();
    do_disable();
    do_enable(5'd12, 40'h0, 0);
    do_req(40'h00_0000_0010, 1'b0, "R7 zero count stays disabled");
    settle();

    // R10: reset in the middle clears entries and settings.
    do_enable(5'd12, 40'h0, 4);
    do_write(1, 40'h00_0012_3003);
    do_req(40'h00_0000_1004, 1'b0, "R3 entry before reset");
    settle();
    do_reset();
    do_req(40'h00_0000_1004, 1'b0, "R10 disabled after reset");
    settle();
    do_enable(5'd12, 40'h0, 4);
    do_req(40'h00_0000_1004, 1'b0, "R10 entry zero after reset");
    settle();

    check(exp_q.size() == 0,
          $sformatf("R1 unanswered requests act=%0d exp=0", exp_q.size()));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule